// File: doc/BRIEF.md
# Reset Cause and Status Controller

This block sequences the core reset of a small 8-bit microcontroller and records why the last reset happened. It has three reset sources. The first is an asynchronous active-low power-on indication. The second is an asynchronous active-low external clear pin. The third is a one-cycle watchdog time-out pulse from the watchdog counter. The core also sends a strobe when it enters its low-power sleep state, and the block keeps a sleep flag from that strobe. At the moment a reset source is seen, the sleep flag decides whether the event counts as a wake-up from sleep or as a reset during normal running. Every wake-up performs a full core reset, so execution never resumes from where it stopped.

The block owns the 8-bit processor status register. Two read-only flags in it, time-out and power-down, together encode the reset cause. Each reset kind clears, sets or keeps each field of the register by its own rule. Outside reset, the core writes the page-select bits and the arithmetic flags through a plain write port. The core reset output stays asserted while any source is active and for a fixed number of cycles after the last source goes away.

Top module: `rst_cause_ctrl`

## Requirements
- R1: While `por_n` is low, `core_rst_n` is 0 and `stat_q` is 8'h18 (page bits 0, time-out bit 4 = 1, power-down bit 3 = 1, zero/digit-carry/carry bits 2..0 = 0). Power-on takes priority over any other source that is active at the same time.
- R2: An external clear during normal running leaves time-out and power-down unchanged.
- R3: An external clear while the sleep flag is set writes time-out = 1 and power-down = 0, and resets the core.
- R4: A watchdog time-out during normal running writes time-out = 0 and power-down = 1.
- R5: A watchdog time-out while the sleep flag is set writes time-out = 0 and power-down = 0, and resets the core.
- R6: An external clear or a watchdog reset clears the page-select bits 7..5 and keeps bits 2..0 at their previous values.
- R7: When the external clear and a watchdog time-out are active in the same cycle, the event is classified as an external clear.
- R8: A watchdog pulse sampled at clock edge E drives `core_rst_n` low after E, and it stays low for exactly HOLD_CYCLES cycles.
- R9: The clear pin passes through a SYNC_STAGES-flop synchronizer. With the core running and the pin low at edge E1, `core_rst_n` is still high after edge E1+SYNC_STAGES-1 and is low after edge E1+SYNC_STAGES. After the pin returns high, `core_rst_n` stays low for SYNC_STAGES+HOLD_CYCLES-1 more cycles.
- R10: A sleep strobe sets the sleep flag only while the core is running. Any reset source clears the flag.
- R11: A status write while the core is running loads bits 7..5 and 2..0 from `stat_wdata` and leaves time-out and power-down unchanged. A write while `core_rst_n` is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| por_n | input | 1 | Power-on indication, active low, asynchronous |
| ext_clr_n | input | 1 | External clear pin, active low, asynchronous |
| wdt_to | input | 1 | Watchdog time-out pulse, synchronous to clk |
| sleep_req | input | 1 | Sleep-entry strobe from the core |
| stat_we | input | 1 | Status register write enable |
| stat_wdata | input | 8 | Status register write data |
| core_rst_n | output | 1 | Core reset, active low |
| stat_q | output | 8 | Status register: page[7:5], time-out[4], power-down[3], zero[2], digit-carry[1], carry[0] |

## Verification
The bench builds the block with SYNC_STAGES = 2 and HOLD_CYCLES = 4. With these values every reset episode lasts only a few cycles, so the bench can sweep all 64 combinations of page bits and arithmetic flags against all four combinations of clear or watchdog with sleep or run. Each reset starts from the time-out/power-down pair left by the one before it. The short pipeline also makes the same-cycle tie between clear and watchdog easy to place exactly. The same holds for the exact entry and exit latency of the reset output.

// File: rtl/rcs_pkg.sv
package rcs_pkg;

  localparam int STAT_W = 8;

  // Bit positions inside the status register
  localparam int TO_BIT = 4;
  localparam int PD_BIT = 3;

  // Bits the core may write: page[7:5] and arithmetic flags [2:0]
  localparam logic [STAT_W-1:0] WR_MASK = 8'hE7;

  // Value forced by power-on
  localparam logic [STAT_W-1:0] STAT_POR = 8'h18;

  typedef enum logic [2:0] {
    EVT_NONE    = 3'd0,
    EVT_POWERON = 3'd1,
    EVT_CLR_RUN = 3'd2,
    EVT_CLR_SLP = 3'd3,
    EVT_WDT_RUN = 3'd4,
    EVT_WDT_SLP = 3'd5
  } rst_evt_e;

endpackage

// File: rtl/rcs_sync.sv
module rcs_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        assign chain_d[s] = d;
      end else begin : g_next
        assign chain_d[s] = chain_q[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/rcs_arbiter.sv
module rcs_arbiter
  import rcs_pkg::*;
(
  input  logic     por_act,
  input  logic     clr_act,
  input  logic     wdt_act,
  input  logic     sleep_q,
  output rst_evt_e evt,
  output logic     any_src
);

  always_comb begin
    any_src = por_act | clr_act | wdt_act;
    if (por_act)      evt = EVT_POWERON;
    else if (clr_act) evt = sleep_q ? EVT_CLR_SLP : EVT_CLR_RUN;
    else if (wdt_act) evt = sleep_q ? EVT_WDT_SLP : EVT_WDT_RUN;
    else              evt = EVT_NONE;
  end

endmodule

// File: rtl/rcs_sleep_trk.sv
module rcs_sleep_trk (
  input  logic clk,
  input  logic rst_n,
  input  logic any_src,
  input  logic core_run,
  input  logic sleep_req,
  output logic sleep_q
);

  logic sleep_d;
  logic sleep_en;

  always_comb begin
    sleep_en = any_src | (sleep_req & core_run);
    sleep_d  = ~any_src;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sleep_q <= 1'b0;
    else if (sleep_en) sleep_q <= sleep_d;
  end

endmodule

// File: rtl/rcs_stretch.sv
module rcs_stretch #(
  parameter int HOLD_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic any_src,
  output logic core_rst_n
);

  localparam int CNT_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [CNT_W-1:0] HOLD_V = CNT_W'(HOLD_CYCLES);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = any_src | (cnt_q != '0);
    cnt_d  = any_src ? HOLD_V : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= HOLD_V;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign core_rst_n = (cnt_q == '0);

endmodule

// File: rtl/rcs_status_reg.sv
module rcs_status_reg
  import rcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  rst_evt_e          evt,
  input  logic              core_run,
  input  logic              wr_en,
  input  logic [STAT_W-1:0] wr_data,
  output logic [STAT_W-1:0] stat_q
);

  logic [STAT_W-1:0] stat_d;
  logic              stat_en;

  always_comb begin
    stat_d  = stat_q;
    stat_en = 1'b0;
    unique case (evt)
      EVT_POWERON: begin
        stat_en = 1'b1;
        stat_d  = STAT_POR;
      end
      EVT_CLR_RUN: begin
        stat_en = 1'b1;
        stat_d  = {3'b000, stat_q[TO_BIT], stat_q[PD_BIT], stat_q[2:0]};
      end
      EVT_CLR_SLP: begin
        stat_en = 1'b1;
        stat_d  = {3'b000, 1'b1, 1'b0, stat_q[2:0]};
      end
      EVT_WDT_RUN: begin
        stat_en = 1'b1;
        stat_d  = {3'b000, 1'b0, 1'b1, stat_q[2:0]};
      end
      EVT_WDT_SLP: begin
        stat_en = 1'b1;
        stat_d  = {3'b000, 1'b0, 1'b0, stat_q[2:0]};
      end
      default: begin
        stat_en = wr_en & core_run;
        stat_d  = (wr_data & WR_MASK) | (stat_q & ~WR_MASK);
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= STAT_POR;
    else if (stat_en) stat_q <= stat_d;
  end

endmodule

// File: rtl/rst_cause_ctrl.sv
module rst_cause_ctrl
  import rcs_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYCLES = 4
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              ext_clr_n,
  input  logic              wdt_to,
  input  logic              sleep_req,
  input  logic              stat_we,
  input  logic [STAT_W-1:0] stat_wdata,
  output logic              core_rst_n,
  output logic [STAT_W-1:0] stat_q
);

  logic     por_ok;
  logic     clr_sync;
  logic     por_act;
  logic     clr_act;
  logic     wdt_act;
  logic     sleep_q;
  logic     any_src;
  rst_evt_e evt;

  // Power-on release, synchronized to clk
  rcs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_por_sync (
    .clk   (clk),
    .rst_n (por_n),
    .d     (1'b1),
    .q     (por_ok)
  );

  // External clear pin synchronizer
  rcs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_clr_sync (
    .clk   (clk),
    .rst_n (por_n),
    .d     (ext_clr_n),
    .q     (clr_sync)
  );

  assign por_act = ~por_ok;
  assign clr_act = ~clr_sync;
  assign wdt_act = wdt_to;

  rcs_arbiter u_arb (
    .por_act (por_act),
    .clr_act (clr_act),
    .wdt_act (wdt_act),
    .sleep_q (sleep_q),
    .evt     (evt),
    .any_src (any_src)
  );

  rcs_sleep_trk u_sleep (
    .clk       (clk),
    .rst_n     (por_n),
    .any_src   (any_src),
    .core_run  (core_rst_n),
    .sleep_req (sleep_req),
    .sleep_q   (sleep_q)
  );

  rcs_stretch #(.HOLD_CYCLES(HOLD_CYCLES)) u_stretch (
    .clk        (clk),
    .rst_n      (por_n),
    .any_src    (any_src),
    .core_rst_n (core_rst_n)
  );

  rcs_status_reg u_stat (
    .clk      (clk),
    .rst_n    (por_n),
    .evt      (evt),
    .core_run (core_rst_n),
    .wr_en    (stat_we),
    .wr_data  (stat_wdata),
    .stat_q   (stat_q)
  );

endmodule

// File: rtl/rcs_chk.sv
module rcs_chk (
  input logic       clk,
  input logic       por_n,
  input logic       por_act,
  input logic       clr_act,
  input logic       wdt_act,
  input logic       sleep_q,
  input logic       sleep_req,
  input logic       core_rst_n,
  input logic [7:0] stat_q
);

  // R1
  poweron_state_chk: assert property (@(posedge clk) disable iff (!por_n)
    por_act |=> (stat_q == 8'h18) && !core_rst_n);

  // R2
  clr_run_keep_chk: assert property (@(posedge clk) disable iff (!por_n)
    (clr_act && !por_act && !sleep_q) |=> $stable(stat_q[4:3]));

  // R3
  clr_wake_chk: assert property (@(posedge clk) disable iff (!por_n)
    (clr_act && !por_act && sleep_q) |=> (stat_q[4:3] == 2'b10) && !core_rst_n);

  // R4
  wdt_run_chk: assert property (@(posedge clk) disable iff (!por_n)
    (wdt_act && !clr_act && !por_act && !sleep_q) |=> (stat_q[4:3] == 2'b01));

  // R5
  wdt_wake_chk: assert property (@(posedge clk) disable iff (!por_n)
    (wdt_act && !clr_act && !por_act && sleep_q) |=> (stat_q[4:3] == 2'b00) && !core_rst_n);

  // R6
  page_arith_chk: assert property (@(posedge clk) disable iff (!por_n)
    ((clr_act || wdt_act) && !por_act) |=>
      (stat_q[7:5] == 3'b000) && (stat_q[2:0] == $past(stat_q[2:0])));

  // R7
  clr_beats_wdt_chk: assert property (@(posedge clk) disable iff (!por_n)
    (clr_act && wdt_act && !por_act && sleep_q) |=> (stat_q[4:3] == 2'b10));

  // R8
  src_holds_rst_chk: assert property (@(posedge clk) disable iff (!por_n)
    (por_act || clr_act || wdt_act) |=> !core_rst_n);

  // R10
  sleep_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
    (por_act || clr_act || wdt_act) |=> !sleep_q);

  // R10
  sleep_set_chk: assert property (@(posedge clk) disable iff (!por_n)
    (sleep_req && core_rst_n && !por_act && !clr_act && !wdt_act) |=> sleep_q);

  // R11
  tp_no_write_chk: assert property (@(posedge clk) disable iff (!por_n)
    (!por_act && !clr_act && !wdt_act) |=> $stable(stat_q[4:3]));

  // R11
  wr_blocked_chk: assert property (@(posedge clk) disable iff (!por_n)
    (!core_rst_n && !por_act && !clr_act && !wdt_act) |=> $stable(stat_q));

endmodule

bind rst_cause_ctrl rcs_chk u_rcs_chk (
  .clk        (clk),
  .por_n      (por_n),
  .por_act    (por_act),
  .clr_act    (clr_act),
  .wdt_act    (wdt_act),
  .sleep_q    (sleep_q),
  .sleep_req  (sleep_req),
  .core_rst_n (core_rst_n),
  .stat_q     (stat_q)
);

// File: tb/tb_rst_cause_ctrl.sv
`timescale 1ns/1ps
module tb_rst_cause_ctrl;

  localparam int SYNC = 2;
  localparam int HOLD = 4;

  logic       clk = 1'b0;
  logic       por_n;
  logic       ext_clr_n;
  logic       wdt_to;
  logic       sleep_req;
  logic       stat_we;
  logic [7:0] stat_wdata;
  logic       core_rst_n;
  logic [7:0] stat_q;

  int n_chk  = 0;
  int n_fail = 0;
  logic [1:0] exp_tp;

  always #2.5 clk = ~clk;

  rst_cause_ctrl #(.SYNC_STAGES(SYNC), .HOLD_CYCLES(HOLD)) dut (
    .clk        (clk),
    .por_n      (por_n),
    .ext_clr_n  (ext_clr_n),
    .wdt_to     (wdt_to),
    .sleep_req  (sleep_req),
    .stat_we    (stat_we),
    .stat_wdata (stat_wdata),
    .core_rst_n (core_rst_n),
    .stat_q     (stat_q)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic nclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_run();
    for (int i = 0; i < 64; i++) begin
      if (core_rst_n === 1'b1) break;
      @(negedge clk);
    end
  endtask

  task automatic wr_stat(input logic [7:0] d);
    stat_we = 1'b1; stat_wdata = d;
    nclk(1);
    stat_we = 1'b0;
  endtask

  task automatic go_sleep();
    sleep_req = 1'b1;
    nclk(1);
    sleep_req = 1'b0;
  endtask

  task automatic pulse_wdt();
    wdt_to = 1'b1;
    nclk(1);
    wdt_to = 1'b0;
  endtask

  task automatic pulse_clr();
    ext_clr_n = 1'b0;
    nclk(3);
    ext_clr_n = 1'b1;
    nclk(1);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    por_n = 1'b0; ext_clr_n = 1'b1; wdt_to = 1'b0;
    sleep_req = 1'b0; stat_we = 1'b0; stat_wdata = 8'h00;
    nclk(3);
    // R1 reset state
    chk("R1 por stat", stat_q, 8'h18);
    chk("R1 por rst", {7'b0, core_rst_n}, 8'h00);
    por_n = 1'b1;
    wait_run();
    chk("R1 after por", stat_q, 8'h18);
    chk("R1 core runs", {7'b0, core_rst_n}, 8'h01);
    exp_tp = 2'b11;

    // R11 writes: time-out/power-down read-only
    wr_stat(8'hFF);
    chk("R11 write ff", stat_q, 8'hFF);
    wr_stat(8'h00);
    chk("R11 write 00", stat_q, 8'h18);

    // Sweep: all page/arith patterns x cause x sleep
    for (int d = 0; d < 64; d++) begin
      for (int k = 0; k < 4; k++) begin
        logic [7:0] wv;
        logic [1:0] tp_prev;
        string tag;
        wv = {d[5:3], 2'b00, d[2:0]};
        wr_stat(wv);
        tp_prev = exp_tp;
        if (k[0]) go_sleep();
        if (k[1]) pulse_wdt(); else pulse_clr();
        case (k)
          0: begin exp_tp = tp_prev; tag = "R2 R6 clr run"; end
          1: begin exp_tp = 2'b10;   tag = "R3 R6 clr sleep"; end
          2: begin exp_tp = 2'b01;   tag = "R4 R6 wdt run"; end
          default: begin exp_tp = 2'b00; tag = "R5 R6 wdt sleep"; end
        endcase
        wait_run();
        chk(tag, stat_q, {3'b000, exp_tp, d[2:0]});
      end
    end

    // R8 exact stretch after a watchdog pulse
    begin
      int lows = 0;
      pulse_wdt();
      for (int i = 0; i < 20; i++) begin
        if (core_rst_n === 1'b0) lows++;
        nclk(1);
      end
      chk("R8 wdt hold", 8'(lows), 8'(HOLD));
      exp_tp = 2'b01;
    end

    // R9 entry latency and release hold of the clear pin
    begin
      int lows = 0;
      ext_clr_n = 1'b0;
      nclk(SYNC);
      chk("R9 not yet", {7'b0, core_rst_n}, 8'h01);
      nclk(1);
      chk("R9 entered", {7'b0, core_rst_n}, 8'h00);
      nclk(2);
      ext_clr_n = 1'b1;
      for (int i = 0; i < 20; i++) begin
        nclk(1);
        if (core_rst_n === 1'b0) lows++;
      end
      chk("R9 release hold", 8'(lows), 8'(SYNC + HOLD - 1));
    end

    // R7 clear and watchdog in the same cycle while sleeping
    wr_stat(8'h05);
    go_sleep();
    ext_clr_n = 1'b0;
    nclk(SYNC);
    wdt_to = 1'b1;
    nclk(1);
    wdt_to = 1'b0;
    nclk(1);
    ext_clr_n = 1'b1;
    wait_run();
    chk("R7 clr wins", stat_q, 8'h15);

    // R10 sleep strobe during core reset is ignored
    pulse_wdt();
    chk("R10 in reset", {7'b0, core_rst_n}, 8'h00);
    go_sleep();
    wait_run();
    pulse_wdt();
    wait_run();
    chk("R10 strobe ignored", stat_q, 8'h0D);

    // R10 a reset clears the sleep flag
    go_sleep();
    pulse_clr();
    wait_run();
    chk("R10 clr wake", stat_q, 8'h15);
    pulse_wdt();
    wait_run();
    chk("R10 flag cleared", stat_q, 8'h0D);

    // R11 write during core reset has no effect
    wr_stat(8'h02);
    pulse_wdt();
    stat_we = 1'b1; stat_wdata = 8'hE7;
    nclk(2);
    stat_we = 1'b0;
    wait_run();
    chk("R11 blocked write", stat_q, 8'h0A);

    // R1 power-on wins over clear and watchdog
    por_n = 1'b0; ext_clr_n = 1'b0; wdt_to = 1'b1;
    nclk(2);
    por_n = 1'b1;
    nclk(1);
    wdt_to = 1'b0;
    nclk(4);
    chk("R1 por priority", stat_q, 8'h18);
    chk("R1 held", {7'b0, core_rst_n}, 8'h00);
    ext_clr_n = 1'b1;
    wait_run();
    chk("R1 R2 after por", stat_q, 8'h18);

    summary();
    $finish;
  end

endmodule